// File: doc/BRIEF.md
# Interrupt and Trap Entry Unit

This block sits beside the issue stage of a processor core and decides, once per cycle, whether control must leave the instruction stream. It combines the pending interrupt lines with their mask and the global enable bit, and weighs them against a synchronous exception raised by the core. When a trap is taken it produces the new mode bits, the cause value, the saved exception PC and a redirect to the trap vector. It also cancels any outstanding load reservation.

When reset is released, the unit issues one boot redirect to the reset PC with the reset mode bits. All results are registered: a request seen at one clock edge appears on the outputs as a pulse lasting exactly one cycle. The cycle after any redirect is a flush shadow in which every request is ignored. The mode bits themselves are held outside the block. The core writes back `st_*` whenever `status_wr` pulses and feeds the current values back on the `cur_*` inputs. All pins are plain control and status signals, because the block has no data stream to throttle.

Top module: `trap_entry_unit`

## Requirements
- R1: Interrupt line i can fire only when `irq_pend[i]` and `irq_mask[i]` are both 1, `cur_ie` is 1 and `issue_valid` is 1. Otherwise it causes no trap.
- R2: When several enabled lines are pending, the lowest index is taken.
- R3: An interrupt cause is the line index in the low bits with a flag bit set at bit 63 when `cur_s64` is 1, or at bit 31 when `cur_s64` is 0. All other bits are zero. An exception cause is `exc_code` zero-extended, with no flag bit.
- R4: On a trap, `st_psup` takes the old `cur_sup` and `st_pie` takes the old `cur_ie`. `st_sup` becomes 1, `st_ie` becomes 0, and `st_s64` keeps `cur_s64`. `status_wr` pulses with these values.
- R5: One cycle after the request edge, `trap_valid` and `redirect_valid` pulse. `epc` then holds `cur_pc` and `redirect_pc` holds `evec`, both as sampled at the request edge.
- R6: A synchronous exception (`exc_valid`=1) takes priority over any pending interrupt in the same cycle. Exceptions do not depend on `cur_ie` or `issue_valid`.
- R7: `resv_clear` pulses in the same cycle as every `trap_valid` pulse.
- R8: At the first clock edge after reset is released, the unit ignores all requests and outputs a single pulse. In that pulse `redirect_valid` and `status_wr` are 1, `trap_valid` is 0, and `redirect_pc` is 0x2000. The mode bits are `st_sup`=1, `st_ie`=0, `st_psup`=0, `st_pie`=0, and `st_s64` equal to the RV64 support parameter (default 1).
- R9: While `rst_n` is 0, `trap_valid`, `redirect_valid`, `status_wr` and `resv_clear` are 0.
- R10: In the cycle after any redirect pulse, requests are ignored, so a request held high produces pulses on every other cycle.
- R11: With no exception and no enabled pending interrupt, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction is about to issue; interrupts are sampled only then |
| irq_pend | input | 8 | Pending interrupt lines |
| irq_mask | input | 8 | Per-line interrupt mask (1 = allowed) |
| cur_ie | input | 1 | Current global interrupt enable |
| cur_sup | input | 1 | Current supervisor-mode bit |
| cur_s64 | input | 1 | Current 64-bit mode bit |
| exc_valid | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Exception cause code |
| cur_pc | input | 64 | PC of the instruction being interrupted or faulting |
| evec | input | 64 | Trap vector address |
| trap_valid | output | 1 | One-cycle pulse: a trap was taken |
| redirect_valid | output | 1 | One-cycle pulse: fetch must restart at redirect_pc |
| redirect_pc | output | 64 | Redirect target (trap vector or reset PC) |
| status_wr | output | 1 | One-cycle pulse: write st_* into the mode state |
| st_sup | output | 1 | New supervisor bit |
| st_psup | output | 1 | New previous-supervisor bit |
| st_ie | output | 1 | New interrupt-enable bit |
| st_pie | output | 1 | New previous-enable bit |
| st_s64 | output | 1 | New 64-bit mode bit |
| cause | output | 64 | Cause of the last trap |
| epc | output | 64 | Saved PC of the last trap |
| resv_clear | output | 1 | One-cycle pulse: cancel the load reservation |

## Verification
The hardest situation to reach is the flush shadow. It needs a request that is still present in the cycle right after a redirect, something a well-behaved core would rarely present. The stimulus holds an exception request high for three cycles and expects pulse, silence, pulse. The boot redirect is checked the same way: requests are already driven in the cycle reset is released. Arbitration corners are reached by mask patterns in which the lowest pending line is masked, so the winner is a higher line.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef struct packed {
    logic sup;
    logic psup;
    logic ie;
    logic pie;
    logic s64;
  } mode_bits_t;

  function automatic mode_bits_t boot_mode(input logic has64);
    mode_bits_t m;
    m.sup  = 1'b1;
    m.psup = 1'b0;
    m.ie   = 1'b0;
    m.pie  = 1'b0;
    m.s64  = has64;
    return m;
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int LINES = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0] pend,
  input  logic [LINES-1:0] mask,
  input  logic             gate,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [LINES-1:0] req;
  logic [LINES-1:0] grant;

  assign req = gate ? (pend & mask) : '0;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_grant
      if (g == 0) begin : g_first
        assign grant[g] = req[g];
      end else begin : g_rest
        assign grant[g] = req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

  assign hit = |grant;

  // R2: at most one line granted, and only a requesting one
  always_comb begin
    if (!$isunknown(req)) begin
      assert_grant_onehot_R2: assert ($onehot0(grant) && ((grant & ~req) == '0))
        else $error("grant not one-hot among requests");
    end
  end
endmodule

// File: rtl/cause_builder.sv
module cause_builder #(
  parameter int XLEN   = 64,
  parameter int IDX_W  = 3,
  parameter int CODE_W = 5
) (
  input  logic              is_irq,
  input  logic              s64,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   cause
);
  logic [XLEN-1:0] flag;

  generate
    if (XLEN > 32) begin : g_wide
      always_comb begin
        flag = '0;
        if (s64) flag[XLEN-1] = 1'b1;
        else     flag[31]     = 1'b1;
      end
    end else begin : g_narrow
      logic unused_s64;
      assign unused_s64 = s64;
      always_comb begin
        flag = '0;
        flag[XLEN-1] = 1'b1;
      end
    end
  endgenerate

  assign cause = is_irq ? (flag | XLEN'(idx)) : XLEN'(code);
endmodule

// File: rtl/mode_pusher.sv
module mode_pusher
  import trap_pkg::*;
(
  input  mode_bits_t cur,
  output mode_bits_t nxt
);
  always_comb begin
    nxt.psup = cur.sup;
    nxt.pie  = cur.ie;
    nxt.sup  = 1'b1;
    nxt.ie   = 1'b0;
    nxt.s64  = cur.s64;
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter int          LINES    = 8,
  parameter int          CODE_W   = 5,
  parameter logic [63:0] RESET_PC = 64'h2000,
  parameter bit          HAS_RV64 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [LINES-1:0]  irq_pend,
  input  logic [LINES-1:0]  irq_mask,
  input  logic              cur_ie,
  input  logic              cur_sup,
  input  logic              cur_s64,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   evec,
  output logic              trap_valid,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              status_wr,
  output logic              st_sup,
  output logic              st_psup,
  output logic              st_ie,
  output logic              st_pie,
  output logic              st_s64,
  output logic [XLEN-1:0]   cause,
  output logic [XLEN-1:0]   epc,
  output logic              resv_clear
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  logic             boot_q;
  logic             blocked;
  logic             irq_hit;
  logic [IDX_W-1:0] irq_idx;
  logic             take_exc;
  logic             take_irq;
  logic             take;
  logic [XLEN-1:0]  cause_d;
  mode_bits_t       cur_mode;
  mode_bits_t       pushed;
  mode_bits_t       mode_q;

  assign blocked = boot_q | redirect_valid;

  irq_arbiter #(.LINES(LINES)) u_arb (
    .pend (irq_pend),
    .mask (irq_mask),
    .gate (issue_valid & cur_ie & ~blocked),
    .hit  (irq_hit),
    .idx  (irq_idx)
  );

  assign take_exc = exc_valid & ~blocked;
  assign take_irq = irq_hit & ~exc_valid;
  assign take     = take_exc | take_irq;

  cause_builder #(.XLEN(XLEN), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_cause (
    .is_irq (~exc_valid),
    .s64    (cur_s64),
    .idx    (irq_idx),
    .code   (exc_code),
    .cause  (cause_d)
  );

  assign cur_mode.sup  = cur_sup;
  assign cur_mode.psup = 1'b0;
  assign cur_mode.ie   = cur_ie;
  assign cur_mode.pie  = 1'b0;
  assign cur_mode.s64  = cur_s64;

  mode_pusher u_push (
    .cur (cur_mode),
    .nxt (pushed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q         <= 1'b1;
      trap_valid     <= 1'b0;
      redirect_valid <= 1'b0;
      status_wr      <= 1'b0;
      resv_clear     <= 1'b0;
      redirect_pc    <= '0;
      cause          <= '0;
      epc            <= '0;
      mode_q         <= '0;
    end else begin
      boot_q         <= 1'b0;
      trap_valid     <= take;
      resv_clear     <= take;
      redirect_valid <= boot_q | take;
      status_wr      <= boot_q | take;
      if (boot_q) begin
        redirect_pc <= XLEN'(RESET_PC);
        mode_q      <= boot_mode(HAS_RV64);
      end else if (take) begin
        redirect_pc <= evec;
        cause       <= cause_d;
        epc         <= cur_pc;
        mode_q      <= pushed;
      end
    end
  end

  assign st_sup  = mode_q.sup;
  assign st_psup = mode_q.psup;
  assign st_ie   = mode_q.ie;
  assign st_pie  = mode_q.pie;
  assign st_s64  = mode_q.s64;

  // R10: every redirect is a lone pulse
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  // R4: trap pushes mode bits
  assert_mode_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (st_sup && !st_ie && st_psup == $past(cur_sup)
                    && st_pie == $past(cur_ie) && st_s64 == $past(cur_s64)));

  // R5: target and saved PC come from the request edge
  assert_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (redirect_pc == $past(evec) && epc == $past(cur_pc)));

  // R6: an exception wins, so its cause carries no flag
  assert_exc_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && $past(exc_valid)) |-> (cause == XLEN'($past(exc_code))));

  // R1: an interrupt trap needs enable and issue
  assert_irq_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !$past(exc_valid)) |-> ($past(cur_ie) && $past(issue_valid)));

  // R7: reservation cancel tracks the trap pulse
  assert_resv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resv_clear |-> (trap_valid && status_wr));
endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic [7:0]  irq_pend, irq_mask;
  logic        cur_ie, cur_sup, cur_s64;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic [63:0] cur_pc, evec;
  logic        trap_valid, redirect_valid, status_wr, resv_clear;
  logic [63:0] redirect_pc, cause, epc;
  logic        st_sup, st_psup, st_ie, st_pie, st_s64;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  trap_entry_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
    .irq_pend(irq_pend), .irq_mask(irq_mask), .cur_ie(cur_ie),
    .cur_sup(cur_sup), .cur_s64(cur_s64), .exc_valid(exc_valid),
    .exc_code(exc_code), .cur_pc(cur_pc), .evec(evec),
    .trap_valid(trap_valid), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .status_wr(status_wr),
    .st_sup(st_sup), .st_psup(st_psup), .st_ie(st_ie), .st_pie(st_pie),
    .st_s64(st_s64), .cause(cause), .epc(epc), .resv_clear(resv_clear)
  );

  typedef struct packed {
    logic        issue;
    logic [7:0]  pend;
    logic [7:0]  mask;
    logic        ie;
    logic        sup;
    logic        s64;
    logic        exc;
    logic [4:0]  code;
    logic [63:0] pc;
    logic [63:0] vec;
    logic        e_trap;
    logic [63:0] e_cause;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h08, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  64'h1000, 64'h8000, 1'b1, 64'h8000_0000_0000_0003},
    '{1'b1, 8'h0C, 8'h08, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0,  64'h1004, 64'h8100, 1'b1, 64'h8000_0000_0000_0003},
    '{1'b1, 8'hA0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  64'h1008, 64'h8200, 1'b1, 64'h0000_0000_8000_0005},
    '{1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  64'h100C, 64'h8300, 1'b0, 64'h0},
    '{1'b1, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  64'h1010, 64'h8400, 1'b0, 64'h0},
    '{1'b0, 8'h01, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  64'h1014, 64'h8500, 1'b0, 64'h0},
    '{1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 5'd13, 64'h1018, 64'h8600, 1'b1, 64'd13},
    '{1'b1, 8'h01, 8'h01, 1'b1, 1'b1, 1'b1, 1'b1, 5'd2,  64'h101C, 64'h8700, 1'b1, 64'd2},
    '{1'b1, 8'h80, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  64'h1020, 64'h8800, 1'b1, 64'h8000_0000_0000_0007},
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 5'd31, 64'h1024, 64'h8900, 1'b1, 64'd31}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    issue_valid = 1'b0; irq_pend = '0; irq_mask = '0; cur_ie = 1'b0;
    cur_sup = 1'b0; cur_s64 = 1'b1; exc_valid = 1'b0; exc_code = '0;
    cur_pc = '0; evec = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    exc_valid = 1'b1; exc_code = 5'd9; issue_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R9: pulses quiet during reset
    chk("R9 trap_valid in reset", 64'(trap_valid), 64'd0);
    chk("R9 redirect_valid in reset", 64'(redirect_valid), 64'd0);
    chk("R9 status_wr in reset", 64'(status_wr), 64'd0);
    chk("R9 resv_clear in reset", 64'(resv_clear), 64'd0);
    // R8: release with a request pending; boot redirect wins
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 boot redirect_valid", 64'(redirect_valid), 64'd1);
    chk("R8 boot trap_valid", 64'(trap_valid), 64'd0);
    chk("R8 boot pc", redirect_pc, 64'h2000);
    chk("R8 boot status_wr", 64'(status_wr), 64'd1);
    chk("R8 boot mode", 64'({st_sup, st_ie, st_psup, st_pie, st_s64}), 64'b10001);
    idle();
    @(negedge clk);
    // R10: shadow after boot swallows the held request
    chk("R10 post-boot shadow", 64'(redirect_valid), 64'd0);
    @(negedge clk);
    chk("R11 idle no pulse", 64'(redirect_valid | trap_valid | status_wr), 64'd0);

    for (int i = 0; i < NV; i++) begin
      issue_valid = VECS[i].issue; irq_pend = VECS[i].pend; irq_mask = VECS[i].mask;
      cur_ie = VECS[i].ie; cur_sup = VECS[i].sup; cur_s64 = VECS[i].s64;
      exc_valid = VECS[i].exc; exc_code = VECS[i].code;
      cur_pc = VECS[i].pc; evec = VECS[i].vec;
      @(negedge clk);
      // R1 R2 R6 R11: whether a trap is taken
      chk($sformatf("R1 R6 R11 vec%0d trap_valid", i), 64'(trap_valid), 64'(VECS[i].e_trap));
      chk($sformatf("R5 vec%0d redirect_valid", i), 64'(redirect_valid), 64'(VECS[i].e_trap));
      chk($sformatf("R7 vec%0d resv_clear", i), 64'(resv_clear), 64'(VECS[i].e_trap));
      if (VECS[i].e_trap) begin
        chk($sformatf("R2 R3 vec%0d cause", i), cause, VECS[i].e_cause);
        chk($sformatf("R5 vec%0d epc", i), epc, VECS[i].pc);
        chk($sformatf("R5 vec%0d redirect_pc", i), redirect_pc, VECS[i].vec);
        chk($sformatf("R4 vec%0d mode", i),
            64'({st_sup, st_ie, st_psup, st_pie, st_s64}),
            64'({1'b1, 1'b0, VECS[i].sup, VECS[i].ie, VECS[i].s64}));
      end else begin
        chk($sformatf("R11 vec%0d status_wr", i), 64'(status_wr), 64'd0);
      end
      idle();
      @(negedge clk);
    end

    // R10: exception held three cycles -> pulse, gap, pulse
    exc_valid = 1'b1; exc_code = 5'd4; cur_pc = 64'h3000; evec = 64'h9000;
    @(negedge clk);
    chk("R10 held req first pulse", 64'(trap_valid), 64'd1);
    @(negedge clk);
    chk("R10 held req shadow", 64'(trap_valid | redirect_valid), 64'd0);
    cur_pc = 64'h3004;
    @(negedge clk);
    chk("R10 held req second pulse", 64'(trap_valid), 64'd1);
    chk("R5 second pulse epc", epc, 64'h3004);
    idle();
    @(negedge clk);

    // R3: 32-bit mode interrupt keeps bit 63 clear
    issue_valid = 1'b1; irq_pend = 8'h02; irq_mask = 8'h02; cur_ie = 1'b1; cur_s64 = 1'b0;
    @(negedge clk);
    chk("R3 narrow flag", cause, 64'h0000_0000_8000_0001);
    idle();
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule